// File: doc/BRIEF.md
# NAND Page Layout Unpacker

This block takes one raw flash page of 2112 bytes as a byte stream and produces the 2048 bytes of user data stored in it. The flash controller that wrote the page interleaved its own layout into the page: a short metadata header, four 512-byte data chunks each followed by a 13-byte parity field, and two unused trailing bytes. Before computing parity, that controller also exchanged the first byte of the page with the byte at offset 0x800. The unpacker removes the header, the parity fields and the padding, and it restores the exchanged byte. Any error correction is assumed to have been applied to the page before it arrives here.

A page begins with a byte flagged as start-of-page. The block writes all 2112 bytes into an internal page buffer. While it fills the buffer it accepts input and produces no output. When the buffer is full it stops accepting input and streams out the user data with a valid/ready handshake, flagging the final byte. It accepts a new page once that final byte has been taken. If a start-of-page arrives while a page is only partly received, the block drops the partial page and reports an error pulse. The new start-of-page byte then opens a fresh page.

Top module: `nand_page_unpack`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `err_abort` is 0.
- R2: A byte accepted with `in_sop`=1 is stored as raw offset 0 of a new page. Bytes accepted while no page is open and without `in_sop` are discarded. They do not start a page and do not cause output.
- R3: Once the 2112th byte of a page has been accepted, `out_valid` is 1 and `in_ready` is 0 in the next cycle. `in_ready` stays 0 for as long as `out_valid` is 1.
- R4: Output byte j (0 to 2047) equals raw byte 10 + (j/512)*525 + (j mod 512). This drops metadata offsets 0–9, the 13 parity bytes after each chunk, and raw offsets 2110–2111.
- R5: Raw offset 0x800 (2048) is replaced by raw offset 0, so output byte 1999 carries raw byte 0.
- R6: Exactly 2048 bytes are transferred per page. `out_last` is 1 only on the 2048th.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R8: A byte accepted with `in_sop`=1 while a page is partly received raises `err_abort` for the following cycle and starts a new page with that byte as raw offset 0. A page without such an event raises no `err_abort`.
- R9: In the cycle after the handshake on the byte with `out_last`, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can take an input byte (buffer filling) |
| in_sop | input | 1 | Input byte is the first byte of a raw page |
| in_data | input | 8 | Raw page byte |
| out_valid | output | 1 | User data byte present |
| out_ready | input | 1 | Consumer takes the output byte |
| out_data | output | 8 | User data byte |
| out_last | output | 1 | Final (2048th) user byte of the page |
| err_abort | output | 1 | One-cycle pulse: partial page dropped on an early start-of-page |

## Verification
The last input byte is accepted on a rising edge. In the cycle after that edge, `out_valid` is high and `in_ready` is low. The output byte is read combinationally from the buffer, so `out_data` and `out_last` are valid in the same cycle as `out_valid`. An early start-of-page shows up on `err_abort` in the cycle after its accepting edge. `in_ready` returns in the cycle after the edge that takes the last output byte. The bench drives inputs and `out_ready` on the falling edge and samples shortly after it, which places each sample in exactly the cycle where the result is due. Backpressure is applied in a fixed pattern so that held output bytes can be compared across stalled cycles.

// File: rtl/unpk_pkg.sv
package unpk_pkg;

    // Raw page geometry
    localparam int META_BYTES   = 10;
    localparam int CHUNK_BYTES  = 512;
    localparam int PARITY_BYTES = 13;
    localparam int NUM_CHUNKS   = 4;
    localparam int PAD_BYTES    = 2;

    localparam int STRIDE_BYTES = CHUNK_BYTES + PARITY_BYTES;
    localparam int USED_BYTES   = META_BYTES + NUM_CHUNKS * STRIDE_BYTES;
    localparam int PAGE_BYTES   = USED_BYTES + PAD_BYTES;
    localparam int OUT_BYTES    = NUM_CHUNKS * CHUNK_BYTES;

    // Marker exchange positions
    localparam int XCHG_LO = 0;
    localparam int XCHG_HI = 2048;

    localparam int AW = $clog2(PAGE_BYTES);
    localparam int OW = $clog2(OUT_BYTES);

    typedef logic [AW-1:0] raw_addr_t;
    typedef logic [OW-1:0] out_idx_t;
    typedef logic [7:0]    byte_t;

    typedef enum logic {
        MODE_FILL  = 1'b0,
        MODE_DRAIN = 1'b1
    } mode_e;

    typedef struct packed {
        logic      we;
        raw_addr_t addr;
    } wr_cmd_t;

    // Map a user byte index to the buffer address holding it,
    // including the marker exchange.
    function automatic raw_addr_t user_to_raw(out_idx_t j);
        int k;
        int o;
        int a;
        k = int'(j) / CHUNK_BYTES;
        o = int'(j) % CHUNK_BYTES;
        a = META_BYTES + k * STRIDE_BYTES + o;
        if (a == XCHG_HI)      a = XCHG_LO;
        else if (a == XCHG_LO) a = XCHG_HI;
        return raw_addr_t'(a);
    endfunction

endpackage

// File: rtl/unpk_page_ram.sv
module unpk_page_ram #(
    parameter int DEPTH = 2112,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/unpk_fill.sv
module unpk_fill
    import unpk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    enable,
    input  logic    in_valid,
    input  logic    in_sop,
    output wr_cmd_t wr_cmd,
    output logic    page_done,
    output logic    abort_pulse
);

    localparam raw_addr_t LAST_RAW = raw_addr_t'(PAGE_BYTES - 1);

    raw_addr_t cnt_q;
    logic      accept;
    logic      page_open;

    assign accept    = enable & in_valid;
    assign page_open = (cnt_q != '0);

    always_comb begin
        wr_cmd.we   = 1'b0;
        wr_cmd.addr = cnt_q;
        if (accept && in_sop) begin
            wr_cmd.we   = 1'b1;
            wr_cmd.addr = '0;
        end else if (accept && page_open) begin
            wr_cmd.we = 1'b1;
        end
    end

    assign page_done = accept && !in_sop && (cnt_q == LAST_RAW);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            abort_pulse <= 1'b0;
        end else begin
            abort_pulse <= accept && in_sop && page_open;
            if (accept) begin
                if (in_sop)              cnt_q <= raw_addr_t'(1);
                else if (page_done)      cnt_q <= '0;
                else if (page_open)      cnt_q <= cnt_q + raw_addr_t'(1);
            end
        end
    end

    AST_FILL_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_RAW) else $error("fill counter out of range"); // R3

    AST_DISCARD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!page_open && in_valid && !in_sop) |=> !page_open)
        else $error("stray byte opened a page"); // R2

endmodule

// File: rtl/unpk_drain.sv
module unpk_drain
    import unpk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      out_ready,
    output raw_addr_t rd_addr,
    output logic      out_valid,
    output logic      out_last,
    output logic      drain_done
);

    localparam out_idx_t LAST_IDX = out_idx_t'(OUT_BYTES - 1);

    out_idx_t idx_q;
    logic     fire;

    assign out_valid  = enable;
    assign fire       = enable & out_ready;
    assign out_last   = enable && (idx_q == LAST_IDX);
    assign drain_done = fire && (idx_q == LAST_IDX);
    assign rd_addr    = user_to_raw(idx_q);

    always_ff @(posedge clk) begin
        if (rst)             idx_q <= '0;
        else if (drain_done) idx_q <= '0;
        else if (fire)       idx_q <= idx_q + out_idx_t'(1);
    end

    always_comb begin
        if (!rst && enable) begin
            AST_RD_IN_LAYOUT: assert (rd_addr < raw_addr_t'(USED_BYTES))
                else $error("read address past used layout"); // R4
        end
    end

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (enable && !out_ready) |=> $stable(idx_q))
        else $error("index moved without handshake"); // R7

endmodule

// File: rtl/nand_page_unpack.sv
module nand_page_unpack
    import unpk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       in_sop,
    input  logic [7:0] in_data,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_last,
    output logic       err_abort
);

    mode_e     mode_q;
    wr_cmd_t   wr_cmd;
    raw_addr_t rd_addr;
    logic      page_done;
    logic      drain_done;

    assign in_ready = (mode_q == MODE_FILL);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_FILL;
        end else begin
            case (mode_q)
                MODE_FILL:  if (page_done)  mode_q <= MODE_DRAIN;
                MODE_DRAIN: if (drain_done) mode_q <= MODE_FILL;
                default:                    mode_q <= MODE_FILL;
            endcase
        end
    end

    unpk_fill fill_i (
        .clk         (clk),
        .rst         (rst),
        .enable      (mode_q == MODE_FILL),
        .in_valid    (in_valid),
        .in_sop      (in_sop),
        .wr_cmd      (wr_cmd),
        .page_done   (page_done),
        .abort_pulse (err_abort)
    );

    unpk_page_ram #(
        .DEPTH (PAGE_BYTES),
        .AW    (AW)
    ) ram_i (
        .clk     (clk),
        .we      (wr_cmd.we),
        .wr_addr (wr_cmd.addr),
        .wr_data (in_data),
        .rd_addr (rd_addr),
        .rd_data (out_data)
    );

    unpk_drain drain_i (
        .clk        (clk),
        .rst        (rst),
        .enable     (mode_q == MODE_DRAIN),
        .out_ready  (out_ready),
        .rd_addr    (rd_addr),
        .out_valid  (out_valid),
        .out_last   (out_last),
        .drain_done (drain_done)
    );

    AST_DRAIN_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready && !in_sop))
        else $error("output began without a completing input byte"); // R3

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)))
        else $error("output changed while stalled"); // R7

    AST_RESUME_FILL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (in_ready && !out_valid))
        else $error("input not reopened after last byte"); // R9

    AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        err_abort |-> $past(in_valid && in_ready && in_sop))
        else $error("abort without a start-of-page"); // R8

endmodule

// File: tb/nand_page_unpack_tb_top.sv
module nand_page_unpack_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic       in_ready;
    logic       in_sop;
    logic [7:0] in_data;
    logic       out_valid;
    logic       out_ready;
    logic [7:0] out_data;
    logic       out_last;
    logic       err_abort;

    int n_checks = 0;
    int n_fail   = 0;
    int err_seen = 0;
    bit run_done = 1'b0;

    always #5 clk = ~clk;

    nand_page_unpack dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_sop    (in_sop),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last),
        .err_abort (err_abort)
    );

    always @(negedge clk) if (err_abort === 1'b1) err_seen++;

    function automatic logic [7:0] raw_b(int s, int i);
        return 8'((i & 255) + (i >> 8) * 17 + s * 29);
    endfunction

    function automatic logic [7:0] exp_b(int s, int j);
        int a;
        a = 10 + (j / 512) * 525 + (j % 512);
        if (a == 2048) a = 0;
        return raw_b(s, a);
    endfunction

    task automatic check(bit ok, string req, int act, int expv, string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic send_range(int seed, int first, int last, bit sop, bit gaps);
        for (int i = first; i <= last; i++) begin
            if (gaps && (i % 7 == 3)) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_sop   = 1'b0;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = sop && (i == first);
            in_data  = raw_b(seed, i);
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        #1;
    endtask

    task automatic expect_drain_start(string tag);
        // R3: out_valid high and in_ready low in the cycle after last input byte
        check(out_valid === 1'b1, "R3", int'(out_valid), 1, {tag, " out_valid after full page"});
        check(in_ready === 1'b0, "R3", int'(in_ready), 0, {tag, " in_ready after full page"});
    endtask

    task automatic collect(int seed, bit bp, string tag);
        int got = 0, bad = 0, first_bad = -1, bad_act = 0, bad_exp = 0;
        int last_pos = -1, last_cnt = 0, guard = 0, stab_err = 0, rdy_err = 0;
        logic [7:0] swap_byte = 8'h00;
        logic [7:0] held = 8'h00;
        bit stalled = 1'b0;
        while (got < 2048 && guard < 20000) begin
            @(negedge clk);
            out_ready = bp ? ((guard % 3) != 1) : 1'b1;
            #1;
            if (stalled && (out_data !== held || out_valid !== 1'b1)) stab_err++;
            if (out_valid && in_ready) rdy_err++;
            if (out_valid && out_ready) begin
                if (out_data !== exp_b(seed, got)) begin
                    bad++;
                    if (first_bad < 0) begin
                        first_bad = got;
                        bad_act = int'(out_data);
                        bad_exp = int'(exp_b(seed, got));
                    end
                end
                if (got == 1999) swap_byte = out_data;
                if (out_last) begin
                    last_pos = got;
                    last_cnt++;
                end
                got++;
            end
            stalled = out_valid && !out_ready;
            held    = out_data;
            guard++;
        end
        @(negedge clk);
        out_ready = 1'b0;
        #1;
        check(bad == 0, "R4", bad_act, bad_exp, {tag, " user byte mismatch (first shown)"});
        check(swap_byte === raw_b(seed, 0), "R5", int'(swap_byte), int'(raw_b(seed, 0)),
              {tag, " byte 1999 holds raw offset 0"});
        check(got == 2048 && last_cnt == 1 && last_pos == 2047, "R6", last_pos, 2047,
              {tag, " last flag position"});
        check(rdy_err == 0, "R3", rdy_err, 0, {tag, " in_ready during output"});
        if (bp) check(stab_err == 0, "R7", stab_err, 0, {tag, " stalled output changed"});
        check(in_ready === 1'b1 && out_valid === 1'b0, "R9", int'(in_ready), 1,
              {tag, " input reopened after last byte"});
    endtask

    task automatic t_reset();
        in_valid  = 1'b0;
        in_sop    = 1'b0;
        in_data   = 8'h00;
        out_ready = 1'b0;
        rst       = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(in_ready === 1'b1, "R1", int'(in_ready), 1, "in_ready after reset");
        check(out_valid === 1'b0, "R1", int'(out_valid), 0, "out_valid after reset");
        check(err_abort === 1'b0, "R1", int'(err_abort), 0, "err_abort after reset");
    endtask

    task automatic t_plain_page();
        int e0 = err_seen;
        send_range(1, 0, 2111, 1'b1, 1'b0);
        expect_drain_start("plain");
        collect(1, 1'b0, "plain");
        check(err_seen == e0, "R8", err_seen - e0, 0, "plain page raised no abort");
    endtask

    task automatic t_gaps_backpressure();
        send_range(2, 0, 2111, 1'b1, 1'b1);
        expect_drain_start("gapped");
        collect(2, 1'b1, "gapped");
    endtask

    task automatic t_stray_bytes();
        // R2: bytes without start-of-page while idle are dropped
        send_range(7, 0, 40, 1'b0, 1'b0);
        check(out_valid === 1'b0, "R2", int'(out_valid), 0, "stray bytes caused output");
        check(in_ready === 1'b1, "R2", int'(in_ready), 1, "stray bytes closed input");
        send_range(3, 0, 2111, 1'b1, 1'b0);
        expect_drain_start("after stray");
        collect(3, 1'b0, "after stray");
    endtask

    task automatic t_abort();
        int e0 = err_seen;
        send_range(4, 0, 99, 1'b1, 1'b0);
        check(err_abort === 1'b0, "R8", int'(err_abort), 0, "no abort before early sop");
        @(negedge clk);
        in_valid = 1'b1;
        in_sop   = 1'b1;
        in_data  = raw_b(5, 0);
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        #1;
        check(err_abort === 1'b1, "R8", int'(err_abort), 1, "abort pulse after early sop");
        send_range(5, 1, 2111, 1'b0, 1'b0);
        expect_drain_start("abort");
        check(err_seen == e0 + 1, "R8", err_seen - e0, 1, "single abort pulse");
        collect(5, 1'b1, "abort restart");
    endtask

    initial begin
        t_reset();
        t_plain_page();
        t_gaps_backpressure();
        t_stray_bytes();
        t_abort();
        t_plain_page();
        run_done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!run_done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule